// File: doc/BRIEF.md
# Tag-Searched Shared Cell Buffer

This block holds cells for several output ports in one common pool of entries. It keeps no head, tail or next pointers and no list of idle addresses. Each entry stores a cell together with a tag made of the destination port and a per-port sequence number, plus an occupied flag. A write takes the lowest-numbered entry whose occupied flag is clear. It stamps the cell with the port's current write sequence number and then advances that counter. A read for a port looks up the entry whose tag equals the port and its current read sequence number. It returns that cell, clears the entry and advances the read counter.

The length of each queue is not kept in a counter of its own. It is the difference of the two sequence numbers of the port, taken modulo the sequence width. One write and one read may be issued in the same cycle. Choosing among several inputs or outputs happens outside the block.

Top module: `cam_cell_buf`

## Requirements
- R1: After reset every queue length is zero and `rd_valid` is low.
- R2: A write with `wr_en` high is accepted, with `wr_ok` high in the same cycle, when at least one entry is free and the destination queue length is below 2^SEQ_W-1. A refused write changes no state.
- R3: Cells read from a port come out in the order they were accepted for that port. `rd_valid` and `rd_data` appear in the cycle after `rd_en`.
- R4: A read of a port whose length is zero gives `rd_valid` low in the next cycle and changes no state.
- R5: `q_len[p*SEQ_W +: SEQ_W]` equals the write sequence minus the read sequence of port p, modulo 2^SEQ_W. It is updated in the cycle after an accepted write or a successful read.
- R6: When all DEPTH entries are occupied, every write is refused.
- R7: When a port's length is 2^SEQ_W-1, writes to that port are refused while other ports still accept.
- R8: An entry freed by a read can be claimed by a write from the next cycle on, so the block holds DEPTH cells in total.
- R9: A write and a read in the same cycle are both carried out. A read of an empty port in the same cycle as a write to that port returns no cell, and the written cell is kept.
- R10: Ordering and lengths stay correct after the sequence numbers wrap around modulo 2^SEQ_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_port | input | PORT_W | Destination port of the cell being written |
| wr_data | input | DATA_W | Cell to store |
| wr_ok | output | 1 | Write accepted this cycle |
| rd_en | input | 1 | Read request |
| rd_port | input | PORT_W | Port to read from |
| rd_valid | output | 1 | `rd_data` holds a cell (one cycle after the request) |
| rd_data | output | DATA_W | Cell read out |
| q_len | output | NPORTS*SEQ_W | Queue length of every port, port p in bits p*SEQ_W and up |

## Verification
The main function is exercised with four kinds of input. Single-port bursts up to the length limit show whether per-port ordering and the limit of R7 hold. A mixed fill to full occupancy separates the global refusal of R6 from the per-port one. Same-cycle read and write pairs show whether a freed entry is reused only from the next cycle and whether a read of an empty queue stays blind to a write in the same cycle. A long seeded random mix runs the sequence numbers through many wraps, so that tag matching after wrap-around is checked against a reference queue model.

// File: rtl/cam_buf_pkg.sv
package cam_buf_pkg;
  // Default sizing of the buffer.
  localparam int DEF_PORTS  = 16;
  localparam int DEF_DEPTH  = 256;
  localparam int DEF_SEQ_W  = 7;
  localparam int DEF_DATA_W = 32;
endpackage

// File: rtl/cbuf_seq_ctr.sv
module cbuf_seq_ctr #(
  parameter int NPORTS = cam_buf_pkg::DEF_PORTS,
  parameter int SEQ_W  = cam_buf_pkg::DEF_SEQ_W,
  localparam int PORT_W = $clog2(NPORTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_inc,
  input  logic [PORT_W-1:0]         wr_port,
  input  logic                      rd_inc,
  input  logic [PORT_W-1:0]         rd_port,
  output logic [SEQ_W-1:0]          wr_seq_sel,
  output logic [SEQ_W-1:0]          rd_seq_sel,
  output logic                      wr_room,
  output logic                      rd_nonempty,
  output logic [NPORTS*SEQ_W-1:0]   len_flat
);
  localparam logic [SEQ_W-1:0] LEN_MAX = '1;

  logic [NPORTS-1:0][SEQ_W-1:0] wr_seq_q, wr_seq_d;
  logic [NPORTS-1:0][SEQ_W-1:0] rd_seq_q, rd_seq_d;
  logic [NPORTS-1:0][SEQ_W-1:0] len;

  for (genvar p = 0; p < NPORTS; p++) begin : g_len
    assign len[p] = wr_seq_q[p] - rd_seq_q[p];
    assign len_flat[p*SEQ_W +: SEQ_W] = len[p];
  end

  assign wr_seq_sel  = wr_seq_q[wr_port];
  assign rd_seq_sel  = rd_seq_q[rd_port];
  assign wr_room     = (len[wr_port] != LEN_MAX);
  assign rd_nonempty = (len[rd_port] != '0);

  always_comb begin
    wr_seq_d = wr_seq_q;
    rd_seq_d = rd_seq_q;
    if (wr_inc) wr_seq_d[wr_port] = wr_seq_q[wr_port] + SEQ_W'(1);
    if (rd_inc) rd_seq_d[rd_port] = rd_seq_q[rd_port] + SEQ_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_seq_q <= '0;
      rd_seq_q <= '0;
    end else begin
      wr_seq_q <= wr_seq_d;
      rd_seq_q <= rd_seq_d;
    end
  end

  // R7
  no_len_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inc |-> wr_room);

  // R5
  len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_inc && !(rd_inc && rd_port == wr_port)) |=>
      len[$past(wr_port)] == SEQ_W'($past(len[wr_port]) + SEQ_W'(1)));
endmodule

// File: rtl/cbuf_free_pick.sv
module cbuf_free_pick #(
  parameter int DEPTH = cam_buf_pkg::DEF_DEPTH,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] occ,
  output logic [IDX_W-1:0] free_idx,
  output logic             any_free
);
  // Lowest-numbered unoccupied entry wins.
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cbuf_tag_search.sv
module cbuf_tag_search #(
  parameter int DEPTH  = cam_buf_pkg::DEF_DEPTH,
  parameter int PORT_W = 4,
  parameter int SEQ_W  = cam_buf_pkg::DEF_SEQ_W,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DEPTH-1:0]              occ,
  input  logic [DEPTH-1:0][PORT_W-1:0]  tag_port,
  input  logic [DEPTH-1:0][SEQ_W-1:0]   tag_seq,
  input  logic [PORT_W-1:0]             key_port,
  input  logic [SEQ_W-1:0]              key_seq,
  output logic                          hit,
  output logic [IDX_W-1:0]              hit_idx
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    assign hit_vec[e] = occ[e] && (tag_port[e] == key_port) && (tag_seq[e] == key_seq);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end
  assign hit = |hit_vec;

  // R3
  tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/cam_cell_buf.sv
module cam_cell_buf #(
  parameter int NPORTS = cam_buf_pkg::DEF_PORTS,
  parameter int DEPTH  = cam_buf_pkg::DEF_DEPTH,
  parameter int SEQ_W  = cam_buf_pkg::DEF_SEQ_W,
  parameter int DATA_W = cam_buf_pkg::DEF_DATA_W,
  localparam int PORT_W = $clog2(NPORTS),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int SUM_W  = PORT_W + SEQ_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [PORT_W-1:0]        wr_port,
  input  logic [DATA_W-1:0]        wr_data,
  output logic                     wr_ok,
  input  logic                     rd_en,
  input  logic [PORT_W-1:0]        rd_port,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic [NPORTS*SEQ_W-1:0]  q_len
);
  logic [DEPTH-1:0]              occ_q, occ_d;
  logic [DEPTH-1:0][PORT_W-1:0]  tag_port_q;
  logic [DEPTH-1:0][SEQ_W-1:0]   tag_seq_q;
  logic [DATA_W-1:0]             cell_q [DEPTH];
  logic                          rd_valid_q;
  logic [DATA_W-1:0]             rd_data_q;

  logic [SEQ_W-1:0] wr_seq, rd_seq;
  logic             wr_room, rd_nonempty, any_free, tag_hit;
  logic [IDX_W-1:0] free_idx, hit_idx;
  logic             wr_fire, rd_fire;
  logic [SUM_W-1:0] occ_sum;

  assign wr_fire = wr_en && any_free && wr_room;
  assign rd_fire = rd_en && rd_nonempty && tag_hit;
  assign wr_ok   = wr_fire;

  cbuf_seq_ctr #(.NPORTS(NPORTS), .SEQ_W(SEQ_W)) i_seq (
    .clk, .rst_n,
    .wr_inc(wr_fire), .wr_port,
    .rd_inc(rd_fire), .rd_port,
    .wr_seq_sel(wr_seq), .rd_seq_sel(rd_seq),
    .wr_room, .rd_nonempty,
    .len_flat(q_len)
  );

  cbuf_free_pick #(.DEPTH(DEPTH)) i_pick (
    .occ(occ_q), .free_idx, .any_free
  );

  cbuf_tag_search #(.DEPTH(DEPTH), .PORT_W(PORT_W), .SEQ_W(SEQ_W)) i_search (
    .clk, .rst_n,
    .occ(occ_q), .tag_port(tag_port_q), .tag_seq(tag_seq_q),
    .key_port(rd_port), .key_seq(rd_seq),
    .hit(tag_hit), .hit_idx
  );

  always_comb begin
    occ_d = occ_q;
    if (rd_fire) occ_d[hit_idx]  = 1'b0;
    if (wr_fire) occ_d[free_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q      <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      occ_q      <= occ_d;
      rd_valid_q <= rd_fire;
    end
  end

  // Payload and tag storage: written under enable, no reset needed.
  always_ff @(posedge clk) begin
    if (wr_fire) begin
      cell_q[free_idx]     <= wr_data;
      tag_port_q[free_idx] <= wr_port;
      tag_seq_q[free_idx]  <= wr_seq;
    end
    if (rd_fire) rd_data_q <= cell_q[hit_idx];
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  always_comb begin
    occ_sum = '0;
    for (int p = 0; p < NPORTS; p++) occ_sum = occ_sum + SUM_W'(q_len[p*SEQ_W +: SEQ_W]);
  end

  // R6
  wr_slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !occ_q[free_idx]);

  // R6
  occupancy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(occ_q) == int'(occ_sum));

  // R3
  read_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_nonempty) |-> tag_hit);

  // R4
  empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_nonempty) |-> !tag_hit);

  // R4
  empty_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_nonempty) |=> !rd_valid);
endmodule

// File: tb/test_cam_cell_buf.sv
`timescale 1ns/1ps
module test_cam_cell_buf;
  localparam int NP = 4;
  localparam int DP = 16;
  localparam int SW = 3;
  localparam int DW = 16;
  localparam int PW = $clog2(NP);
  localparam int LMAX = (1 << SW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, rd_en;
  logic [PW-1:0] wr_port, rd_port;
  logic [DW-1:0] wr_data;
  logic wr_ok, rd_valid;
  logic [DW-1:0] rd_data;
  logic [NP*SW-1:0] q_len;

  int total = 0;
  int bad = 0;

  // Reference queues
  logic [DW-1:0] mq [NP][8];
  int mhead [NP];
  int mcnt  [NP];
  int mtot;

  always #2.5 clk = ~clk;

  cam_cell_buf #(.NPORTS(NP), .DEPTH(DP), .SEQ_W(SW), .DATA_W(DW)) i_cam_cell_buf (
    .clk, .rst_n, .wr_en, .wr_port, .wr_data, .wr_ok,
    .rd_en, .rd_port, .rd_valid, .rd_data, .q_len
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_accept(input logic we, input int p);
    return we && (mtot < DP) && (mcnt[p] < LMAX);
  endfunction

  function automatic string accept_req(input int p);
    if (mtot >= DP) return "R6";
    if (mcnt[p] >= LMAX) return "R7";
    return "R2";
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic we, input int wp, input logic [DW-1:0] wd,
                      input logic re, input int rp, input string phase);
    bit e_ok, e_rv;
    logic [DW-1:0] e_rd;
    string rq;
    wr_en = we; wr_port = PW'(wp); wr_data = wd;
    rd_en = re; rd_port = PW'(rp);
    #1;
    e_ok = exp_accept(we, wp);
    rq = accept_req(wp);
    chk(wr_ok === e_ok, rq, {phase, " wr_ok"}, longint'(wr_ok), longint'(e_ok));
    e_rv = re && (mcnt[rp] > 0);
    e_rd = '0;
    if (e_rv) begin
      e_rd = mq[rp][mhead[rp]];
      mhead[rp] = (mhead[rp] + 1) % 8;
      mcnt[rp]--;
      mtot--;
    end
    if (e_ok) begin
      mq[wp][(mhead[wp] + mcnt[wp]) % 8] = wd;
      mcnt[wp]++;
      mtot++;
    end
    @(posedge clk);
    #1;
    chk(rd_valid === e_rv, e_rv ? "R3" : "R4", {phase, " rd_valid"},
        longint'(rd_valid), longint'(e_rv));
    if (e_rv) chk(rd_data === e_rd, "R3", {phase, " rd_data"}, longint'(rd_data), longint'(e_rd));
    for (int p = 0; p < NP; p++)
      chk(int'(q_len[p*SW +: SW]) == mcnt[p], "R5", {phase, " q_len"},
          longint'(q_len[p*SW +: SW]), longint'(mcnt[p]));
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int p = 0; p < NP; p++) begin mhead[p] = 0; mcnt[p] = 0; end
    mtot = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_port = '0; rd_port = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(rd_valid === 1'b0, "R1", "reset rd_valid", longint'(rd_valid), 0);
    chk(q_len === '0, "R1", "reset q_len", longint'(q_len), 0);

    // R4 empty read
    step(1'b0, 0, '0, 1'b1, 2, "R4 empty");

    // R7 per-port limit, then in-order drain (R3)
    for (int k = 0; k < LMAX + 1; k++) step(1'b1, 1, DW'(16'h100 + k), 1'b0, 0, "R7 burst");
    step(1'b1, 2, 16'h0bad, 1'b0, 0, "R7 other port");
    for (int k = 0; k < LMAX + 1; k++) step(1'b0, 0, '0, 1'b1, 1, "R3 drain");
    step(1'b0, 0, '0, 1'b1, 2, "R3 drain");

    // R6 fill to full occupancy
    for (int k = 0; k < LMAX; k++) step(1'b1, 0, DW'(16'h200 + k), 1'b0, 0, "R6 fill");
    for (int k = 0; k < LMAX; k++) step(1'b1, 2, DW'(16'h300 + k), 1'b0, 0, "R6 fill");
    for (int k = 0; k < DP - 2*LMAX; k++) step(1'b1, 3, DW'(16'h400 + k), 1'b0, 0, "R6 fill");
    step(1'b1, 3, 16'h0eee, 1'b0, 0, "R6 full");
    step(1'b1, 1, 16'h0eef, 1'b0, 0, "R6 full");

    // R8 freed entry reused next cycle, not same cycle
    step(1'b1, 3, 16'h0aaa, 1'b1, 0, "R8 same-cycle");
    step(1'b1, 3, 16'h0aab, 1'b0, 0, "R8 next-cycle");

    // drain everything
    for (int k = 0; k < DP; k++) step(1'b0, 0, '0, 1'b1, k % NP, "R3 empty-out");
    for (int k = 0; k < DP; k++) step(1'b0, 0, '0, 1'b1, k % NP, "R3 empty-out");

    // R9 write and read of the same empty port in one cycle
    step(1'b1, 1, 16'h0555, 1'b1, 1, "R9 blind");
    step(1'b1, 1, 16'h0556, 1'b1, 1, "R9 both");
    step(1'b0, 0, '0, 1'b1, 1, "R9 tail");

    // R10 random mix, sequence numbers wrap many times
    for (int k = 0; k < 4000; k++) begin
      logic we, re;
      we = ($urandom % 100) < 55;
      re = ($urandom % 100) < 50;
      step(we, int'($urandom % NP), DW'($urandom), re, int'($urandom % NP), "R10 random");
    end

    wr_en = 1'b0; rd_en = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule